// File: doc/BRIEF.md
# GPIO Edge Event Status Unit

This block watches a set of already-synchronised, debounced GPIO input levels and turns their edges into latched events. Each pin has an enable bit and a polarity bit. The polarity bit decides which edge counts as the pin's "assert" event, and the opposite edge is its "deassert" event. The two kinds of event are held in two separate status words, and each word drives its own interrupt line. Setting polarity to 1 and watching both status words gives detection on both edges.

Software reaches the block through a small word-wide register port: an address, a write strobe, write data and combinational read data. In a status word, pin n sits at bit n+1. Bit 0 of a write to a status word chooses the operation. With bit 0 at 0 the write clears the selected bits, and with bit 0 at 1 it sets them, so software can also inject events.

Top module: `gpev_top`

## Requirements
- R1: After reset, the enable word (address 0) reads 0, the polarity word (address 1) reads all ones in bits 0..NPINS-1, both status words (address 2 assert, address 3 deassert) read 0, and both interrupt outputs are low.
- R2: With polarity 1 on an enabled pin n, a rising input edge sets bit n+1 of the assert status word and a falling edge sets bit n+1 of the deassert status word. The bit is visible at the first clock edge after the input change.
- R3: With polarity 0 on an enabled pin n, a falling edge sets bit n+1 of the assert status word and a rising edge sets bit n+1 of the deassert status word.
- R4: An edge on a pin whose enable bit is 0 sets neither status word. The raw levels can still be read at address 4.
- R5: A write to a status word with bit 0 = 0 clears every status bit whose data bit (1..31) is 1 and leaves the other status bits unchanged.
- R6: A write to a status word with bit 0 = 1 sets every status bit whose data bit (1..31) is 1 and leaves the other status bits unchanged.
- R7: Bit 0 of both status words always reads 0. A status write with only bit 0 set changes nothing. The enable and polarity words read back only bits 0..NPINS-1.
- R8: The assert interrupt is high exactly when any assert status bit is set, and the deassert interrupt is high exactly when any deassert status bit is set.
- R9: When a hardware event and a software clear hit the same status bit in the same cycle, the bit stays set. Other bits cleared by that write still clear.
- R10: A level held steady from reset onward never produces an event, even after its pin is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | NPINS | Synchronised, debounced pin levels |
| reg_addr | input | 3 | Register word select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational on reg_addr) |
| irq_assert | output | 1 | Any assert status bit set |
| irq_deassert | output | 1 | Any deassert status bit set |

## Verification
On every cycle, the assertions check that bit 0 of a status read is zero and that status words stay frozen while no pin is enabled and no write occurs. They also check that every detected event is present in the status word one cycle later, which covers the event-over-clear priority. Finally, they check that an interrupt only falls after a write and only rises after a write or an event, and that status is clean right after reset. The mapping from polarity to edge direction, the exact clear and set masks, the bit n+1 placement at both ends of the pin range, and the absence of false edges from levels held since reset can only be shown by the bench's directed scenarios.

// File: rtl/gpev_pkg.sv
package gpev_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;
    localparam int MAX_PINS = REG_W - 1;

    typedef enum logic [ADDR_W-1:0] {
        A_ENABLE    = 3'd0,
        A_POLARITY  = 3'd1,
        A_ST_ASSERT = 3'd2,
        A_ST_DEASRT = 3'd3,
        A_LEVEL     = 3'd4
    } reg_addr_e;

    // Operation chosen by bit 0 of a status write
    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_SET   = 1'b1
    } st_op_e;

    typedef struct packed {
        logic   hit;
        st_op_e op;
    } st_cmd_t;

    function automatic st_cmd_t decode_status_cmd(input logic wr, input logic addr_match,
                                                  input logic op_bit);
        st_cmd_t c;
        c.hit = wr & addr_match;
        c.op  = st_op_e'(op_bit);
        return c;
    endfunction
endpackage

// File: rtl/gpev_edge_detect.sv
module gpev_edge_detect #(
    parameter int NPINS = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_lvl,
    input  logic [NPINS-1:0] en,
    input  logic [NPINS-1:0] pol,
    output logic [NPINS-1:0] evt_a,
    output logic [NPINS-1:0] evt_d
);
    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] rise;
    logic [NPINS-1:0] fall;

    // Previous level follows the pins during reset too, so no edge is seen on release
    always_ff @(posedge clk) begin
        if (rst) prev_q <= pin_lvl;
        else     prev_q <= pin_lvl;
    end

    assign rise = pin_lvl & ~prev_q;
    assign fall = ~pin_lvl & prev_q;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign evt_a[i] = en[i] & (pol[i] ? rise[i] : fall[i]);
        assign evt_d[i] = en[i] & (pol[i] ? fall[i] : rise[i]);
    end
endmodule

// File: rtl/gpev_cfg_regs.sv
module gpev_cfg_regs #(
    parameter int NPINS = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_hit,
    input  logic             wr_pol_hit,
    input  logic [NPINS-1:0] wr_bits,
    output logic [NPINS-1:0] en_q,
    output logic [NPINS-1:0] pol_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            pol_q <= '1;
        end else begin
            if (wr_en_hit)  en_q  <= wr_bits;
            if (wr_pol_hit) pol_q <= wr_bits;
        end
    end
endmodule

// File: rtl/gpev_status_reg.sv
module gpev_status_reg
    import gpev_pkg::*;
#(
    parameter int NPINS = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  st_cmd_t          cmd,
    input  logic [NPINS-1:0] wr_mask,
    input  logic [NPINS-1:0] evt,
    output logic [NPINS-1:0] st_q,
    output logic             irq
);
    logic [NPINS-1:0] sw_nxt;
    logic [NPINS-1:0] st_nxt;

    always_comb begin
        sw_nxt = st_q;
        if (cmd.hit) begin
            if (cmd.op == ST_SET) sw_nxt = st_q | wr_mask;
            else                  sw_nxt = st_q & ~wr_mask;
        end
        // Hardware events are merged last so they override a clear
        st_nxt = sw_nxt | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_nxt;
    end

    assign irq = |st_q;
endmodule

// File: rtl/gpev_top.sv
module gpev_top
    import gpev_pkg::*;
#(
    parameter int NPINS = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_lvl,
    input  logic [2:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq_assert,
    output logic             irq_deassert
);
    localparam int ST_HI = NPINS;

    logic [NPINS-1:0] en_q;
    logic [NPINS-1:0] pol_q;
    logic [NPINS-1:0] evt_a;
    logic [NPINS-1:0] evt_d;
    logic [NPINS-1:0] st_a;
    logic [NPINS-1:0] st_d;
    logic [NPINS-1:0] st_mask;
    st_cmd_t          cmd_a;
    st_cmd_t          cmd_d;

    initial begin
        if (NPINS < 1 || NPINS > MAX_PINS) $error("NPINS out of range");
    end

    assign st_mask = reg_wdata[ST_HI:1];
    assign cmd_a   = decode_status_cmd(reg_wr, reg_addr == A_ST_ASSERT, reg_wdata[0]);
    assign cmd_d   = decode_status_cmd(reg_wr, reg_addr == A_ST_DEASRT, reg_wdata[0]);

    gpev_cfg_regs #(.NPINS(NPINS)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_en_hit  (reg_wr && reg_addr == A_ENABLE),
        .wr_pol_hit (reg_wr && reg_addr == A_POLARITY),
        .wr_bits    (reg_wdata[NPINS-1:0]),
        .en_q       (en_q),
        .pol_q      (pol_q)
    );

    gpev_edge_detect #(.NPINS(NPINS)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .pin_lvl (pin_lvl),
        .en      (en_q),
        .pol     (pol_q),
        .evt_a   (evt_a),
        .evt_d   (evt_d)
    );

    gpev_status_reg #(.NPINS(NPINS)) u_st_a (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd_a),
        .wr_mask (st_mask),
        .evt     (evt_a),
        .st_q    (st_a),
        .irq     (irq_assert)
    );

    gpev_status_reg #(.NPINS(NPINS)) u_st_d (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd_d),
        .wr_mask (st_mask),
        .evt     (evt_d),
        .st_q    (st_d),
        .irq     (irq_deassert)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_ENABLE:    reg_rdata[NPINS-1:0] = en_q;
            A_POLARITY:  reg_rdata[NPINS-1:0] = pol_q;
            A_ST_ASSERT: reg_rdata[ST_HI:1]   = st_a;
            A_ST_DEASRT: reg_rdata[ST_HI:1]   = st_d;
            A_LEVEL:     reg_rdata[NPINS-1:0] = pin_lvl;
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpev_chk.sv
module gpev_chk #(
    parameter int NPINS = 31
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic [31:0]      reg_rdata,
    input logic             irq_assert,
    input logic             irq_deassert,
    input logic [NPINS-1:0] en_q,
    input logic [NPINS-1:0] evt_a,
    input logic [NPINS-1:0] evt_d,
    input logic [NPINS-1:0] st_a,
    input logic [NPINS-1:0] st_d
);
    assert_bit0_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 3'd2 || reg_addr == 3'd3) |-> (reg_rdata[0] == 1'b0));

    assert_idle_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && en_q == '0) |=> ($stable(st_a) && $stable(st_d)));

    assert_event_wins_a_R9: assert property (@(posedge clk) disable iff (rst)
        (|evt_a) |=> ((st_a & $past(evt_a)) == $past(evt_a)));

    assert_event_lands_d_R2: assert property (@(posedge clk) disable iff (rst)
        (|evt_d) |=> ((st_d & $past(evt_d)) == $past(evt_d)));

    assert_irq_falls_on_write_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(irq_assert) || $fell(irq_deassert)) |-> $past(reg_wr));

    assert_irq_rises_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_assert) |-> ($past(reg_wr) || $past(|evt_a)));

    assert_clean_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_assert && !irq_deassert));
endmodule

bind gpev_top gpev_chk #(.NPINS(NPINS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .irq_assert   (irq_assert),
    .irq_deassert (irq_deassert),
    .en_q         (en_q),
    .evt_a        (evt_a),
    .evt_d        (evt_d),
    .st_a         (st_a),
    .st_d         (st_d)
);

// File: tb/gpev_top_tb.sv
module gpev_top_tb;
    localparam int NP = 31;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pins = '0;
    logic [2:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq_assert;
    logic          irq_deassert;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    gpev_top #(.NPINS(NP)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .pin_lvl      (pins),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .irq_assert   (irq_assert),
        .irq_deassert (irq_deassert)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic setpin(input int idx, input logic val);
        @(negedge clk);
        pins[idx] = val;
        @(negedge clk);
    endtask

    task automatic clr_all();
        wr(3'd2, 32'hFFFF_FFFE);
        wr(3'd3, 32'hFFFF_FFFE);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); chk("R1 enable", v, 32'h0);
        rd(3'd1, v); chk("R1 polarity", v, 32'h7FFF_FFFF);
        rd(3'd2, v); chk("R1 assert st", v, 32'h0);
        rd(3'd3, v); chk("R1 deassert st", v, 32'h0);
        chk("R1 irqs", {30'd0, irq_assert, irq_deassert}, 32'h0);
    endtask

    task automatic t_static();
        logic [31:0] v;
        wr(3'd0, 32'h7FFF_FFFF);
        repeat (4) @(negedge clk);
        rd(3'd2, v); chk("R10 assert st", v, 32'h0);
        rd(3'd3, v); chk("R10 deassert st", v, 32'h0);
    endtask

    task automatic t_pol1();
        logic [31:0] v;
        setpin(0, 1'b1);
        rd(3'd2, v); chk("R2 rise->assert", v, 32'h0000_0002);
        rd(3'd3, v); chk("R2 rise no deassert", v, 32'h0);
        chk("R8 irqs after rise", {30'd0, irq_assert, irq_deassert}, 32'h2);
        setpin(0, 1'b0);
        rd(3'd3, v); chk("R2 fall->deassert", v, 32'h0000_0002);
        chk("R8 both irqs", {30'd0, irq_assert, irq_deassert}, 32'h3);
        setpin(30, 1'b0);
        rd(3'd3, v); chk("R2 pin30 at bit31", v, 32'h8000_0002);
        clr_all();
        chk("R8 irqs clear", {30'd0, irq_assert, irq_deassert}, 32'h0);
    endtask

    task automatic t_set_clear();
        logic [31:0] v;
        wr(3'd2, 32'h0000_0015);
        rd(3'd2, v); chk("R6 set mask", v, 32'h0000_0014);
        wr(3'd2, 32'h0000_0004);
        rd(3'd2, v); chk("R5 partial clear", v, 32'h0000_0010);
        rd(3'd3, v); chk("R5 other word untouched", v, 32'h0);
        wr(3'd2, 32'h0000_0010);
        rd(3'd2, v); chk("R5 full clear", v, 32'h0);
        chk("R8 irq low", {31'd0, irq_assert}, 32'h0);
    endtask

    task automatic t_pol0();
        logic [31:0] v;
        wr(3'd1, 32'h7FFF_FFFD);
        setpin(1, 1'b1);
        rd(3'd3, v); chk("R3 rise->deassert", v, 32'h0000_0004);
        rd(3'd2, v); chk("R3 rise no assert", v, 32'h0);
        setpin(1, 1'b0);
        rd(3'd2, v); chk("R3 fall->assert", v, 32'h0000_0004);
        clr_all();
        wr(3'd1, 32'h7FFF_FFFF);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        wr(3'd0, 32'h7FFF_FFFB);
        setpin(2, 1'b1);
        rd(3'd4, v); chk("R4 level visible", v, {1'b0, pins});
        rd(3'd2, v); chk("R4 no assert", v, 32'h0);
        setpin(2, 1'b0);
        rd(3'd3, v); chk("R4 no deassert", v, 32'h0);
        chk("R4 irqs low", {30'd0, irq_assert, irq_deassert}, 32'h0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        wr(3'd2, 32'h0000_0041);
        @(negedge clk);
        pins[3] = 1'b1;
        reg_addr = 3'd2; reg_wdata = 32'h0000_0050; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(3'd2, v); chk("R9 event beats clear", v, 32'h0000_0010);
        clr_all();
    endtask

    task automatic t_bit0();
        logic [31:0] v;
        wr(3'd2, 32'h0000_0001);
        rd(3'd2, v); chk("R7 bit0-only write", v, 32'h0);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, v); chk("R7 bit0 reads 0", v, 32'hFFFF_FFFE);
        chk("R8 deassert irq", {31'd0, irq_deassert}, 32'h1);
        clr_all();
        rd(3'd3, v); chk("R5 clear all", v, 32'h0);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); chk("R7 enable width", v, 32'h7FFF_FFFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        pins[5]  = 1'b1;
        pins[30] = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_static();
        t_pol1();
        t_set_clear();
        t_pol0();
        t_disabled();
        t_race();
        t_bit0();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule